// File: doc/BRIEF.md
# Transmit Frame Serializer with Hardware FCS

This block turns a frame that a host has placed in a byte-addressed buffer into a byte stream for a transmit baseband. A one-cycle start strobe begins a frame. The block reads two control bytes at the bottom of the buffer: the header length at address 0x000 and the frame length L at address 0x001. If both are valid, it sends the synchronization preamble, the start-of-frame delimiter and a PHY length byte, which it generates itself. It then streams the L stored bytes (frame control, sequence number and data). It can close the frame with a two-byte frame check sequence that it computes while the bytes go out and never writes back to the buffer.

The buffer port is synchronous. The address is driven with a read enable, and the data returns one cycle later. Bytes leave through a valid/ready handshake, so the baseband can stall the stream at any byte. An internal queue tracks outstanding reads against free slots, so the stream runs at one byte per cycle whenever the baseband is ready. A frame with an illegal length is rejected before any byte leaves. Every accepted start ends with exactly one done pulse, and an error flag marks a rejected frame.

Top module: `txf_serializer`

## Requirements
- R1: After reset and while idle, out_valid, done, err and rd_en are all low.
- R2: Every accepted frame begins with four bytes of value 0x00 followed by one byte 0xA7, each sent exactly once.
- R3: The sixth byte of a frame is the PHY length: the stored frame length L (buffer address 0x001) plus 2 when FCS is enabled, and L unchanged when it is disabled.
- R4: Before streaming, the block reads address 0x000 (header length) and address 0x001 (frame length, with one cycle of read latency). After the PHY length byte it sends the bytes at addresses 0x002 through 0x001+L in ascending address order.
- R5: With FCS enabled, two bytes follow the last stored byte. They hold a CRC-16 with polynomial x^16+x^12+x^5+1 and a zero initial value, taken over the L stored bytes with each byte fed least significant bit first. The low byte of the CRC is sent first, and neither byte is read from the buffer.
- R6: The FCS enable input is sampled when a start is accepted. Later changes have no effect on the frame in progress.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R8: A start pulse while a frame is in progress is ignored, and each accepted start produces exactly one done pulse.
- R9: When L is below 3 or above 125, the frame is aborted: done pulses with err high and no byte is sent.
- R10: When the header length exceeds L, the frame is aborted in the same way as in R9.
- R11: On a successful frame, done is a one-cycle pulse with err low, raised after the last byte has been accepted. No further byte appears until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to send the staged frame |
| fcs_en | input | 1 | Append the computed FCS when high (sampled at start) |
| rd_en | output | 1 | Buffer read enable |
| rd_addr | output | ADDR_W | Buffer read address |
| rd_data | input | 8 | Buffer read data, valid one cycle after rd_en |
| out_valid | output | 1 | Byte on out_data is valid |
| out_ready | input | 1 | Baseband accepts the byte this cycle |
| out_data | output | 8 | Outgoing byte |
| done | output | 1 | One-cycle pulse at the end of a frame or an abort |
| err | output | 1 | High with done when the frame was aborted |

## Verification
A wrong sequencer state or counter shows up in the byte stream itself. A lost or repeated preamble byte, a shifted payload address or a wrong length byte appears as a mismatch at the very next handshake. A corrupted CRC register can only show in the two closing bytes, so it is found one frame-length later. A known nine-byte vector pins the CRC's bit order. Queue accounting errors appear as bytes that change under backpressure, as dropped payload bytes, or as a done pulse that comes early or never comes. Random stalls on out_ready expose these within a few cycles.

// File: rtl/txf_pkg.sv
`timescale 1ns/1ps
package txf_pkg;

   localparam int BYTE_W = 8;
   localparam int CRC_W  = 16;

   localparam logic [BYTE_W-1:0] TXF_PRE_BYTE = 8'h00;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HDR,
      ST_LEN,
      ST_CHK,
      ST_PRE,
      ST_SFD,
      ST_PLEN,
      ST_DATA,
      ST_FCS_LO,
      ST_FCS_HI,
      ST_DRAIN
   } txf_state_e;

endpackage

// File: rtl/txf_crc16.sv
`timescale 1ns/1ps
module txf_crc16 import txf_pkg::*; #(
   parameter logic [CRC_W-1:0] POLY      = 16'h1021,
   parameter logic [CRC_W-1:0] INIT      = 16'h0000,
   parameter bit               LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              upd,
   input  logic [BYTE_W-1:0] din,
   output logic [CRC_W-1:0]  crc
);

   function automatic logic [CRC_W-1:0] rev_poly(input logic [CRC_W-1:0] v);
      logic [CRC_W-1:0] r;
      for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
      return r;
   endfunction

   localparam logic [CRC_W-1:0] POLY_R = rev_poly(POLY);

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nxt;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_comb begin
            crc_nxt = crc_q;
            for (int i = 0; i < BYTE_W; i++) begin
               logic fb;
               fb      = crc_nxt[0] ^ din[i];
               crc_nxt = crc_nxt >> 1;
               if (fb) crc_nxt = crc_nxt ^ POLY_R;
            end
         end
      end else begin : g_msb
         always_comb begin
            crc_nxt = crc_q;
            for (int i = 0; i < BYTE_W; i++) begin
               logic fb;
               fb      = crc_nxt[CRC_W-1] ^ din[BYTE_W-1-i];
               crc_nxt = crc_nxt << 1;
               if (fb) crc_nxt = crc_nxt ^ POLY;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= INIT;
      else if (clear) crc_q <= INIT;
      else if (upd)   crc_q <= crc_nxt;
   end

   assign crc = crc_q;

   assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (crc == INIT));

endmodule

// File: rtl/txf_byte_fifo.sv
`timescale 1ns/1ps
module txf_byte_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] level
);

   localparam int PTR_W = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH+1);

   initial begin
      assert_depth_pow2_R7: assert (DEPTH >= 2 && (DEPTH & (DEPTH-1)) == 0)
         else $error("txf_byte_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [LVL_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign dout  = mem[rp_q];
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == LVL_W'(DEPTH));
   assign level = cnt_q;

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/txf_len_check.sv
`timescale 1ns/1ps
module txf_len_check #(
   parameter int W       = 8,
   parameter int MIN_LEN = 3,
   parameter int MAX_LEN = 125
) (
   input  logic [W-1:0] hdr_len,
   input  logic [W-1:0] frm_len,
   output logic         bad
);

   localparam logic [W-1:0] LO = W'(MIN_LEN);
   localparam logic [W-1:0] HI = W'(MAX_LEN);

   logic too_short, too_long, hdr_over;

   always_comb begin
      too_short = (frm_len < LO);
      too_long  = (frm_len > HI);
      hdr_over  = (hdr_len > frm_len);
      bad       = too_short | too_long | hdr_over;
   end

endmodule

// File: rtl/txf_serializer.sv
`timescale 1ns/1ps
module txf_serializer import txf_pkg::*; #(
   parameter int                ADDR_W        = 9,
   parameter int                PRE_LEN       = 4,
   parameter logic [BYTE_W-1:0] SFD_VAL       = 8'hA7,
   parameter int                MIN_LEN       = 3,
   parameter int                MAX_LEN       = 125,
   parameter int                FIFO_DEPTH    = 4,
   parameter logic [CRC_W-1:0]  CRC_POLY      = 16'h1021,
   parameter logic [CRC_W-1:0]  CRC_INIT      = 16'h0000,
   parameter bit                CRC_LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              fcs_en,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BYTE_W-1:0] out_data,
   output logic              done,
   output logic              err
);

   localparam int                LVL_W     = $clog2(FIFO_DEPTH+1);
   localparam int                FCS_BYTES = CRC_W / BYTE_W;
   localparam logic [BYTE_W-1:0] PRE_LAST  = BYTE_W'(PRE_LEN - 1);
   localparam logic [BYTE_W-1:0] FCS_ADD   = BYTE_W'(FCS_BYTES);
   localparam logic [ADDR_W-1:0] HDR_ADDR  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] LEN_ADDR  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] BODY_BASE = ADDR_W'(2);

   initial begin
      assert_pre_len_R2: assert (PRE_LEN >= 1 && PRE_LEN <= 255)
         else $error("txf_serializer: PRE_LEN out of range");
      assert_len_window_R9: assert (MIN_LEN >= 1 && MIN_LEN <= MAX_LEN && MAX_LEN + FCS_BYTES <= 255)
         else $error("txf_serializer: MIN_LEN/MAX_LEN inconsistent");
      assert_addr_fits_R4: assert ((1 << ADDR_W) >= MAX_LEN + 2)
         else $error("txf_serializer: ADDR_W too small for MAX_LEN");
   end

   txf_state_e        st_q, st_n;
   logic [BYTE_W-1:0] cnt_q, cnt_n;
   logic [BYTE_W-1:0] len_q, len_n;
   logic [BYTE_W-1:0] hdr_q, hdr_n;
   logic              fcs_q, fcs_n;
   logic              inf_q, inf_n;
   logic              done_q, done_n;
   logic              err_q, err_n;

   logic              push;
   logic [BYTE_W-1:0] push_d;
   logic              pop;
   logic              f_empty, f_full;
   logic [LVL_W-1:0]  f_level;
   logic [LVL_W:0]    occ;
   logic              room;
   logic              crc_clr, crc_upd;
   logic [CRC_W-1:0]  crc;
   logic              len_bad;

   txf_len_check #(
      .W       (BYTE_W),
      .MIN_LEN (MIN_LEN),
      .MAX_LEN (MAX_LEN)
   ) u_len (
      .hdr_len (hdr_q),
      .frm_len (rd_data),
      .bad     (len_bad)
   );

   txf_crc16 #(
      .POLY      (CRC_POLY),
      .INIT      (CRC_INIT),
      .LSB_FIRST (CRC_LSB_FIRST)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (crc_clr),
      .upd   (crc_upd),
      .din   (push_d),
      .crc   (crc)
   );

   txf_byte_fifo #(
      .W     (BYTE_W),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   (push_d),
      .pop   (pop),
      .dout  (out_data),
      .empty (f_empty),
      .full  (f_full),
      .level (f_level)
   );

   assign out_valid = !f_empty;
   assign pop       = out_valid && out_ready;
   assign occ       = {1'b0, f_level} + (LVL_W+1)'(inf_q);
   assign room      = (occ < (LVL_W+1)'(FIFO_DEPTH));

   always_comb begin
      st_n    = st_q;
      cnt_n   = cnt_q;
      len_n   = len_q;
      hdr_n   = hdr_q;
      fcs_n   = fcs_q;
      inf_n   = 1'b0;
      done_n  = 1'b0;
      err_n   = 1'b0;
      rd_en   = 1'b0;
      rd_addr = '0;
      push    = 1'b0;
      push_d  = '0;
      crc_clr = 1'b0;
      crc_upd = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (start) begin
               st_n    = ST_HDR;
               fcs_n   = fcs_en;
               crc_clr = 1'b1;
            end
         end
         ST_HDR: begin
            rd_en   = 1'b1;
            rd_addr = HDR_ADDR;
            st_n    = ST_LEN;
         end
         ST_LEN: begin
            rd_en   = 1'b1;
            rd_addr = LEN_ADDR;
            hdr_n   = rd_data;
            st_n    = ST_CHK;
         end
         ST_CHK: begin
            len_n = rd_data;
            cnt_n = '0;
            if (len_bad) begin
               st_n   = ST_IDLE;
               done_n = 1'b1;
               err_n  = 1'b1;
            end else begin
               st_n = ST_PRE;
            end
         end
         ST_PRE: begin
            if (room) begin
               push   = 1'b1;
               push_d = TXF_PRE_BYTE;
               if (cnt_q == PRE_LAST) begin
                  st_n  = ST_SFD;
                  cnt_n = '0;
               end else begin
                  cnt_n = cnt_q + 8'd1;
               end
            end
         end
         ST_SFD: begin
            if (room) begin
               push   = 1'b1;
               push_d = SFD_VAL;
               st_n   = ST_PLEN;
            end
         end
         ST_PLEN: begin
            if (room) begin
               push   = 1'b1;
               push_d = fcs_q ? (len_q + FCS_ADD) : len_q;
               st_n   = ST_DATA;
               cnt_n  = '0;
            end
         end
         ST_DATA: begin
            if (inf_q) begin
               push    = 1'b1;
               push_d  = rd_data;
               crc_upd = 1'b1;
            end
            if (cnt_q != len_q) begin
               if (room) begin
                  rd_en   = 1'b1;
                  rd_addr = ADDR_W'(cnt_q) + BODY_BASE;
                  cnt_n   = cnt_q + 8'd1;
                  inf_n   = 1'b1;
               end
            end else if (!inf_q) begin
               st_n = fcs_q ? ST_FCS_LO : ST_DRAIN;
            end
         end
         ST_FCS_LO: begin
            if (room) begin
               push   = 1'b1;
               push_d = crc[BYTE_W-1:0];
               st_n   = ST_FCS_HI;
            end
         end
         ST_FCS_HI: begin
            if (room) begin
               push   = 1'b1;
               push_d = crc[CRC_W-1:BYTE_W];
               st_n   = ST_DRAIN;
            end
         end
         ST_DRAIN: begin
            if (f_empty) begin
               st_n   = ST_IDLE;
               done_n = 1'b1;
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         len_q  <= '0;
         hdr_q  <= '0;
         fcs_q  <= 1'b0;
         inf_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_n;
         cnt_q  <= cnt_n;
         len_q  <= len_n;
         hdr_q  <= hdr_n;
         fcs_q  <= fcs_n;
         inf_q  <= inf_n;
         done_q <= done_n;
         err_q  <= err_n;
      end
   end

   assign done = done_q;
   assign err  = err_q;

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> (!out_valid && !rd_en));
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && st_q != ST_IDLE) |=> (st_q != ST_HDR));
   assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/txf_serializer_test.sv
`timescale 1ns/1ps
module txf_serializer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       fcs_en = 1'b0;
   logic       rd_en;
   logic [8:0] rd_addr;
   logic [7:0] rd_data;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [7:0] out_data;
   logic       done;
   logic       err;

   always #2.5 clk = ~clk;

   txf_serializer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .fcs_en    (fcs_en),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .done      (done),
      .err       (err)
   );

   logic [7:0] bmem [512];
   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= bmem[rd_addr];
   end

   int         compared = 0;
   int         mismatched = 0;
   logic [7:0] expq [$];
   string      tagq [$];
   bit         exp_err = 1'b0;
   bit         pending = 1'b0;
   int         rmode = 0;
   bit         finished = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
         else             r = r >> 1;
      end
      return r;
   endfunction

   always begin
      @(posedge clk);
      #1;
      out_ready = (rmode == 0) ? 1'b1 : ($urandom_range(0, 3) != 0);
   end

   // Scoreboard monitor
   bit         prev_stall = 1'b0;
   logic [7:0] prev_data = 8'h00;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall) begin
            chk(out_valid === 1'b1 && out_data === prev_data, "R7 hold under stall",
                {out_valid, out_data}, {1'b1, prev_data});
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
         if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R8/R9/R11 unexpected byte", out_data, 0);
            end else begin
               logic [7:0] e;
               string      t;
               e = expq.pop_front();
               t = tagq.pop_front();
               chk(out_data === e, t, out_data, e);
            end
         end
         if (done) begin
            if (!pending) begin
               chk(1'b0, "R8 extra done", 1, 0);
            end else begin
               chk(err === exp_err, "R11 err flag at done", err, exp_err);
               chk(expq.size() == 0, "R11 done after last byte", expq.size(), 0);
               pending = 1'b0;
            end
         end
      end
   end

   task automatic send_frame(input logic [7:0] hdr, input logic [7:0] len, input bit fcs,
                             input bit restart, input bit flip, input bit lit,
                             input logic [15:0] lit_crc);
      bit          bad;
      logic [15:0] c;
      int          n;
      bmem[0] = hdr;
      bmem[1] = len;
      bad = (len < 8'd3) || (len > 8'd125) || (hdr > len);
      if (bad) begin
         exp_err = 1'b1;   // R9 / R10: nothing on the wire
      end else begin
         exp_err = 1'b0;
         for (int i = 0; i < 4; i++) begin expq.push_back(8'h00); tagq.push_back("R2 preamble"); end
         expq.push_back(8'hA7); tagq.push_back("R2 sfd");
         expq.push_back(fcs ? len + 8'd2 : len); tagq.push_back("R3 phy length");
         c = 16'h0000;
         for (int i = 0; i < int'(len); i++) begin
            expq.push_back(bmem[2+i]); tagq.push_back("R4 body byte");
            c = crc_byte(c, bmem[2+i]);
         end
         if (lit) c = lit_crc;
         if (fcs) begin
            expq.push_back(c[7:0]);  tagq.push_back("R5 fcs low");
            expq.push_back(c[15:8]); tagq.push_back("R5 fcs high");
         end
      end
      pending = 1'b1;
      fcs_en  = fcs;
      start   = 1'b1;
      tick();
      start   = 1'b0;
      if (flip) fcs_en = !fcs;   // R6: must not affect this frame
      if (restart) begin
         repeat (8) tick();
         start = 1'b1;           // R8: ignored mid-frame
         tick();
         start = 1'b0;
      end
      n = 0;
      while (pending && n < 5000) begin
         tick();
         n++;
      end
      chk(!pending, "R11 done within bound", pending, 0);
      if (pending) begin
         pending = 1'b0;
         expq.delete();
         tagq.delete();
      end
      repeat (12) tick();
   endtask

   initial begin
      for (int i = 0; i < 512; i++) bmem[i] = 8'h00;
      repeat (5) tick();
      @(negedge clk);
      chk(!out_valid && !done && !err && !rd_en, "R1 reset state",
          {out_valid, done, err, rd_en}, 0);
      rst_n = 1'b1;
      repeat (3) tick();
      @(negedge clk);
      chk(!out_valid && !done && !rd_en, "R1 idle after reset", {out_valid, done, rd_en}, 0);
      tick();

      // R5 known vector: ASCII "123456789" gives CRC 0x2189
      for (int i = 0; i < 9; i++) bmem[2+i] = 8'h31 + 8'(i);
      send_frame(8'd3, 8'd9, 1'b1, 1'b0, 1'b0, 1'b1, 16'h2189);

      // R3 / R4 shortest legal frame
      bmem[2] = 8'h41; bmem[3] = 8'h88; bmem[4] = 8'h5C;
      send_frame(8'd3, 8'd3, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);

      // R6 longest frame, FCS off, enable flipped after start; random stalls (R7)
      rmode = 1;
      for (int i = 0; i < 125; i++) bmem[2+i] = 8'((i * 37) ^ 8'h5A);
      send_frame(8'd7, 8'd125, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);

      // R6 reverse: FCS on, enable dropped after start
      for (int i = 0; i < 30; i++) bmem[2+i] = 8'($urandom);
      send_frame(8'd5, 8'd30, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0);

      // R8 second start mid-frame is ignored
      for (int i = 0; i < 40; i++) bmem[2+i] = 8'($urandom);
      send_frame(8'd9, 8'd40, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);

      // R9 length bounds, R10 header longer than frame
      send_frame(8'd0, 8'd2,   1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      send_frame(8'd0, 8'd0,   1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      send_frame(8'd3, 8'd126, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      send_frame(8'd9, 8'd5,   1'b1, 1'b0, 1'b0, 1'b0, 16'h0);

      // Recovery after aborts, full rate then stalled
      rmode = 0;
      for (int i = 0; i < 60; i++) bmem[2+i] = 8'($urandom);
      send_frame(8'd60, 8'd60, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      rmode = 1;
      send_frame(8'd4, 8'd60, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);

      @(negedge clk);
      chk(!out_valid && !done, "R11 quiet after frame", {out_valid, done}, 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule